// File: doc/BRIEF.md
# Scan-Driven System Bus Access Engine

This block lets a debug host reach the on-chip system bus through the test access port. The TAP controller is outside this block. It supplies one-cycle strobes for instruction update, data-register capture and data-register update, along with the current instruction code and the bits just scanned in. The engine turns these strobes into requests on a simple request/acknowledge bus master. That master has a 36-bit address, a 2-bit size code, a write flag and 32-bit data. On every data-register capture, the engine loads a status word. Bit 0 of that word is the busy flag and the bits above it hold the most recent read data, so the host sees status before any data bits come out.

A normal access takes two data scans. The first carries the address and control bits and the second carries the data. There is a short-address mode that reaches 32-bit registers in a fixed window, and a streaming mode that needs only one data scan per transfer and steps the address by the size of the last transfer. A countdown mode holds busy for a host-chosen number of cycles. A cancel instruction abandons a pending transfer. While busy is set, every new request is dropped without effect, and the host retries.

Top module: `dbg_bus_bridge`

## Requirements
- R1: After reset, busy is clear, `bus_req` and `bus_write` are low, and a capture returns all zeros.
- R2: Instruction codes are 1 = sized, 2 = word, 3 = register window, 4 = streaming, 5 = cancel and 6 = countdown. For sized and word instructions, an address scan uses `scan_in[0]` as the read flag (1 = read), `scan_in[2:1]` as the size (0 byte, 1 halfword, 2 word) and `scan_in[38:3]` as the address. The word instruction forces size 2. `bus_addr`, `bus_size`, `bus_write` and `bus_wdata` stay stable while a request waits for its acknowledge.
- R3: A write address scan starts no bus access. The following data scan issues the write with `scan_in[31:0]` as data and sets busy.
- R4: In register window mode, the address scan takes the index from `scan_in[7:1]`. The bus address is REG_BASE + 4 × index and the size is word.
- R5: A read address scan issues the read and sets busy at once. The acknowledge clears busy and stores `bus_rdata`. A capture loads `scan_out[0]` = busy and `scan_out[32:1]` = stored read data.
- R6: A data update made while busy is ignored. An ignored address scan is discarded and the engine stays in its address phase, so the repeated address scan is taken as an address.
- R7: In streaming mode, each data update made while not busy advances the address by 1, 2 or 4 for size 0, 1 or 2 of the previous transfer. It then issues an access in the same direction, and a write uses `scan_in[31:0]`.
- R8: Selecting streaming mode issues a read at the advanced address in the same update, but only if the previous transfer was a read whose data has already been scanned out. Otherwise it issues nothing.
- R9: A data update under the countdown instruction loads N from `scan_in[15:0]`. Busy then stays set for exactly N+1 cycles after the update edge.
- R10: A cancel instruction update drops `bus_req` in that same cycle and clears busy at the next edge. An acknowledge arriving after that leaves the stored read data unchanged.
- R11: An instruction update other than cancel, made while busy, leaves the pending request running to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_update | input | 1 | Instruction update strobe |
| dr_capture | input | 1 | Data-register capture strobe |
| dr_update | input | 1 | Data-register update strobe |
| instr | input | 4 | Current instruction code |
| scan_in | input | 39 | Scanned-in data register contents |
| scan_out | output | 33 | Captured status word: busy at bit 0, read data above |
| bus_req | output | 1 | Bus request |
| bus_addr | output | 36 | Bus byte address |
| bus_size | output | 2 | Transfer size code |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Bus acknowledge |
| bus_rdata | input | 32 | Bus read data |

## Verification
An update strobe sampled at edge E makes `bus_req` and the held address visible after E. The bench drives strobes at the falling edge and reads results at the next falling edge. A cancel lowers `bus_req` combinationally, so the bench checks it one time unit after driving the strobe, before any edge. `scan_out` reflects the state before the capture edge and is read at the falling edge after it. For the countdown, the capture is placed so it samples at edges E+N+1 (expect busy) and E+N+2 (expect clear).

// File: rtl/dbgb_pkg.sv
package dbgb_pkg;
  localparam int INSTR_W = 4;

  localparam logic [INSTR_W-1:0] OP_SIZED  = 4'h1;
  localparam logic [INSTR_W-1:0] OP_WORD   = 4'h2;
  localparam logic [INSTR_W-1:0] OP_REGWIN = 4'h3;
  localparam logic [INSTR_W-1:0] OP_STREAM = 4'h4;
  localparam logic [INSTR_W-1:0] OP_CANCEL = 4'h5;
  localparam logic [INSTR_W-1:0] OP_COUNT  = 4'h6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dbgb_addr_decode.sv
module dbgb_addr_decode
  import dbgb_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int IDX_W  = 7,
  parameter logic [ADDR_W-1:0] REG_BASE = 36'hF_FFFF_FE00
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W+2:0]  scan_in,
  output logic               is_access,
  output logic               rd_flag,
  output logic [1:0]         size,
  output logic [ADDR_W-1:0]  addr
);
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] win_addr;

  assign idx      = scan_in[IDX_W:1];
  assign win_addr = REG_BASE + (ADDR_W'(idx) << 2);
  assign rd_flag  = scan_in[0];

  always_comb begin
    is_access = 1'b0;
    size      = scan_in[2:1];
    addr      = scan_in[ADDR_W+2:3];
    case (instr)
      OP_SIZED: is_access = 1'b1;
      OP_WORD: begin
        is_access = 1'b1;
        size      = SZ_WORD;
      end
      OP_REGWIN: begin
        is_access = 1'b1;
        size      = SZ_WORD;
        addr      = win_addr;
      end
      default: is_access = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbgb_count_timer.sv
module dbgb_count_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic             run_q, run_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign done = run_q && (cnt_q == '0) && !clear;

  always_comb begin
    run_n = run_q;
    cnt_n = cnt_q;
    if (clear) begin
      run_n = 1'b0;
      cnt_n = '0;
    end else if (load) begin
      run_n = 1'b1;
      cnt_n = load_val;
    end else if (run_q) begin
      if (cnt_q == '0) run_n = 1'b0;
      else             cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/dbgb_bus_port.sv
module dbgb_bus_port #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cancel,
  input  logic              is_write,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_req,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  logic              req_q, req_n;
  logic [DATA_W-1:0] rdata_q, rdata_n;

  assign bus_req = req_q && !cancel;
  assign done    = req_q && bus_ack && !cancel;
  assign rdata   = rdata_q;

  always_comb begin
    req_n   = req_q;
    rdata_n = rdata_q;
    if (cancel)     req_n = 1'b0;
    else if (start) req_n = 1'b1;
    else if (done)  req_n = 1'b0;
    if (done && !is_write) rdata_n = bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      req_q   <= req_n;
      rdata_q <= rdata_n;
    end
  end
endmodule

// File: rtl/dbg_bus_bridge.sv
module dbg_bus_bridge
  import dbgb_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 7,
  parameter int CNT_W  = 16,
  parameter logic [ADDR_W-1:0] REG_BASE = 36'hF_FFFF_FE00,
  localparam int SCAN_W = ADDR_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ir_update,
  input  logic               dr_capture,
  input  logic               dr_update,
  input  logic [INSTR_W-1:0] instr,
  input  logic [SCAN_W-1:0]  scan_in,
  output logic [DATA_W:0]    scan_out,
  output logic               bus_req,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [1:0]         bus_size,
  output logic               bus_write,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_ack,
  input  logic [DATA_W-1:0]  bus_rdata
);
  // registered state
  phase_e            phase_q, phase_n;
  logic              busy_q, busy_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [1:0]        size_q, size_n;
  logic              wr_q, wr_n;
  logic [DATA_W-1:0] wdata_q, wdata_n;
  logic              rd_seen_q, rd_seen_n;
  logic [DATA_W:0]   cap_q, cap_n;

  // control strobes
  logic              cancel;
  logic              start;
  logic              cnt_load;
  logic              bus_done;
  logic              cnt_done;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] step_addr;

  // decoded address scan
  logic              dec_access;
  logic              dec_rd;
  logic [1:0]        dec_size;
  logic [ADDR_W-1:0] dec_addr;

  assign cancel    = ir_update && (instr == OP_CANCEL);
  assign step_addr = addr_q + ADDR_W'(size_bytes(size_q));

  dbgb_addr_decode #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .REG_BASE(REG_BASE)
  ) u_decode (
    .instr    (instr),
    .scan_in  (scan_in),
    .is_access(dec_access),
    .rd_flag  (dec_rd),
    .size     (dec_size),
    .addr     (dec_addr)
  );

  dbgb_count_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .clear   (cancel),
    .load_val(scan_in[CNT_W-1:0]),
    .done    (cnt_done)
  );

  dbgb_bus_port #(
    .DATA_W(DATA_W)
  ) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cancel   (cancel),
    .is_write (wr_q),
    .bus_ack  (bus_ack),
    .bus_rdata(bus_rdata),
    .bus_req  (bus_req),
    .done     (bus_done),
    .rdata    (rd_data)
  );

  always_comb begin
    phase_n   = phase_q;
    busy_n    = busy_q;
    addr_n    = addr_q;
    size_n    = size_q;
    wr_n      = wr_q;
    wdata_n   = wdata_q;
    rd_seen_n = rd_seen_q;
    start     = 1'b0;
    cnt_load  = 1'b0;
    cap_n     = dr_capture ? {rd_data, busy_q} : cap_q;

    if (cancel) begin
      busy_n  = 1'b0;
      phase_n = PH_ADDR;
    end else begin
      if (bus_done || cnt_done) busy_n = 1'b0;

      if (ir_update && !busy_q) begin
        phase_n = PH_ADDR;
        if (instr == OP_STREAM && !wr_q && rd_seen_q) begin
          addr_n    = step_addr;
          start     = 1'b1;
          busy_n    = 1'b1;
          rd_seen_n = 1'b0;
        end
      end

      if (dr_update && !busy_q) begin
        if (dec_access && phase_q == PH_ADDR) begin
          addr_n  = dec_addr;
          size_n  = dec_size;
          wr_n    = !dec_rd;
          phase_n = PH_DATA;
          if (dec_rd) begin
            start     = 1'b1;
            busy_n    = 1'b1;
            rd_seen_n = 1'b0;
          end
        end else if (dec_access) begin
          phase_n = PH_ADDR;
          if (wr_q) begin
            wdata_n = scan_in[DATA_W-1:0];
            start   = 1'b1;
            busy_n  = 1'b1;
          end else begin
            rd_seen_n = 1'b1;
          end
        end else if (instr == OP_STREAM) begin
          addr_n    = step_addr;
          start     = 1'b1;
          busy_n    = 1'b1;
          rd_seen_n = 1'b0;
          if (wr_q) wdata_n = scan_in[DATA_W-1:0];
        end else if (instr == OP_COUNT) begin
          cnt_load = 1'b1;
          busy_n   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_ADDR;
      busy_q    <= 1'b0;
      addr_q    <= '0;
      size_q    <= SZ_BYTE;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      rd_seen_q <= 1'b0;
      cap_q     <= '0;
    end else begin
      phase_q   <= phase_n;
      busy_q    <= busy_n;
      addr_q    <= addr_n;
      size_q    <= size_n;
      wr_q      <= wr_n;
      wdata_q   <= wdata_n;
      rd_seen_q <= rd_seen_n;
      cap_q     <= cap_n;
    end
  end

  assign scan_out  = cap_q;
  assign bus_addr  = addr_q;
  assign bus_size  = size_q;
  assign bus_write = wr_q;
  assign bus_wdata = wdata_q;
endmodule

// File: rtl/dbgb_checker.sv
module dbgb_checker #(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ir_update,
  input logic              dr_update,
  input logic [3:0]        instr,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              busy,
  input logic [DATA_W-1:0] rdata
);
  logic cancel_seen;
  assign cancel_seen = ir_update && (instr == 4'h5);

  assert_cancel_drops_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_seen |-> !bus_req);

  assert_cancel_clears_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_seen |=> !busy);

  assert_late_ack_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && bus_ack) |=> $stable(rdata));

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_write)
                               && $stable(bus_size) && $stable(bus_wdata)));

  assert_busy_ignores_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_update && busy) |=> ($stable(bus_addr) && $stable(bus_write)));

  assert_req_implies_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);

  assert_read_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !bus_write) |=> (rdata == $past(bus_rdata)));

  assert_done_clears_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> !busy);
endmodule

bind dbg_bus_bridge dbgb_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ir_update(ir_update),
  .dr_update(dr_update),
  .instr    (instr),
  .bus_req  (bus_req),
  .bus_ack  (bus_ack),
  .bus_write(bus_write),
  .bus_addr (bus_addr),
  .bus_size (bus_size),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .busy     (busy_q),
  .rdata    (rd_data)
);

// File: tb/dbg_bus_bridge_bench.sv
module dbg_bus_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [35:0] WIN_BASE = 36'hF_FFFF_FE00;

  logic        clk;
  logic        rst_n;
  logic        ir_update, dr_capture, dr_update;
  logic [3:0]  instr;
  logic [38:0] scan_in;
  logic [32:0] scan_out;
  logic        bus_req, bus_write;
  logic [35:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic        slv_ack, stray_ack, bus_ack;
  logic [31:0] bus_rdata, stray_data, slv_data;

  int checks = 0;
  int errors = 0;

  // slave model state
  int          lat = 2;
  logic        hold = 1'b0;
  int          wcnt = 0;
  int          txn = 0;
  logic [35:0] log_addr;
  logic [1:0]  log_size;
  logic        log_write;
  logic [31:0] log_wdata;

  assign bus_ack   = slv_ack | stray_ack;
  assign bus_rdata = stray_ack ? stray_data : slv_data;

  dbg_bus_bridge u_dbg_bus_bridge (
    .clk(clk), .rst_n(rst_n), .ir_update(ir_update), .dr_capture(dr_capture),
    .dr_update(dr_update), .instr(instr), .scan_in(scan_in), .scan_out(scan_out),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_val(input logic [35:0] a);
    return a[31:0] ^ 32'h5A5A_0F0F;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      slv_ack = 1'b0;
      wcnt = 0;
    end else if (slv_ack) begin
      slv_ack = 1'b0;
      wcnt = 0;
    end else if (bus_req && !hold) begin
      if (wcnt >= lat) begin
        slv_ack   = 1'b1;
        slv_data  = mem_val(bus_addr);
        log_addr  = bus_addr;
        log_size  = bus_size;
        log_write = bus_write;
        log_wdata = bus_wdata;
        txn++;
      end else wcnt++;
    end else wcnt = 0;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ir(input logic [3:0] code);
    @(negedge clk);
    instr = code;
    ir_update = 1'b1;
    @(negedge clk);
    ir_update = 1'b0;
  endtask

  task automatic dr(input logic [38:0] val, output logic [32:0] cap);
    @(negedge clk);
    dr_capture = 1'b1;
    @(negedge clk);
    dr_capture = 1'b0;
    cap = scan_out;
    scan_in = val;
    dr_update = 1'b1;
    @(negedge clk);
    dr_update = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!bus_req) break;
    end
  endtask

  // {instr, rd, size, addr/index, wdata, exp_addr, exp_size}
  localparam logic [112:0] VEC [6] = '{
    {4'h1, 1'b1, 2'd0, 36'h1_2345_6781, 32'h0,           36'h1_2345_6781, 2'd0},
    {4'h1, 1'b0, 2'd1, 36'h8_0000_0102, 32'hCAFE_0001,   36'h8_0000_0102, 2'd1},
    {4'h2, 1'b1, 2'd0, 36'hF_0000_1000, 32'h0,           36'hF_0000_1000, 2'd2},
    {4'h2, 1'b0, 2'd1, 36'h0_0000_0044, 32'h1234_5678,   36'h0_0000_0044, 2'd2},
    {4'h3, 1'b1, 2'd0, 36'h0_0000_0005, 32'h0,           36'hF_FFFF_FE14, 2'd2},
    {4'h3, 1'b0, 2'd0, 36'h0_0000_007F, 32'hA0A0_5050,   36'hF_FFFF_FFFC, 2'd2}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [32:0] cap;
    int t0;
    rst_n = 1'b0; ir_update = 1'b0; dr_capture = 1'b0; dr_update = 1'b0;
    instr = 4'h0; scan_in = '0; stray_ack = 1'b0; stray_data = '0; slv_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 bus_req", 64'(bus_req), 64'd0);
    check("R1 bus_write", 64'(bus_write), 64'd0);
    dr('0, cap);
    check("R1 capture", 64'(cap), 64'd0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 6; i++) begin
      logic [112:0] v;
      logic [3:0]  vi;
      logic        vr;
      logic [1:0]  vs;
      logic [35:0] va, ea;
      logic [31:0] vw;
      logic [1:0]  es;
      logic [38:0] sv;
      v = VEC[i];
      {vi, vr, vs, va, vw, ea, es} = v;
      t0 = txn;
      ir(vi);
      sv = (vi == 4'h3) ? 39'({va[6:0], vr}) : {va, vs, vr};
      dr(sv, cap);
      if (vr) begin
        wait_idle();
        dr('0, cap);
        check("R5 busy clear after read", 64'(cap[0]), 64'd0);
        check("R5 read data", 64'(cap[32:1]), 64'(mem_val(ea)));
      end else begin
        check("R3 no access on write address", 64'(txn - t0), 64'd0);
        dr(39'(vw), cap);
        wait_idle();
        check("R3 write data", 64'(log_wdata), 64'(vw));
      end
      check(vi == 4'h3 ? "R4 window address" : "R2 address", 64'(log_addr), 64'(ea));
      check("R2 size", 64'(log_size), 64'(es));
      check("R2 direction", 64'(log_write), 64'(!vr));
    end

    // R8 streaming start after scanned read
    ir(4'h1);
    dr({36'h0_0000_2000, 2'd2, 1'b1}, cap);
    wait_idle();
    dr('0, cap);
    ir(4'h4);
    check("R8 stream start request", 64'(bus_req), 64'd1);
    wait_idle();
    check("R8 stream start address", 64'(log_addr), 64'h2004);
    // R7 streaming read step
    dr('0, cap);
    check("R7 stream read data", 64'(cap[32:1]), 64'(mem_val(36'h2004)));
    wait_idle();
    check("R7 stream read address", 64'(log_addr), 64'h2008);

    // R7 streaming halfword writes
    ir(4'h1);
    dr({36'h0_0000_0100, 2'd1, 1'b0}, cap);
    dr(39'h1111, cap);
    wait_idle();
    ir(4'h4);
    check("R8 no start after write", 64'(bus_req), 64'd0);
    dr(39'h2222, cap);
    wait_idle();
    check("R7 stream write address", 64'(log_addr), 64'h102);
    check("R7 stream write data", 64'(log_wdata), 64'h2222);
    dr(39'h3333, cap);
    wait_idle();
    check("R7 stream write next", 64'(log_addr), 64'h104);

    // R7 byte step with unscanned read
    ir(4'h1);
    dr({36'h0_0000_02FF, 2'd0, 1'b1}, cap);
    wait_idle();
    ir(4'h4);
    check("R8 no start before data scanned", 64'(bus_req), 64'd0);
    dr('0, cap);
    check("R7 byte read data", 64'(cap[32:1]), 64'(mem_val(36'h2FF)));
    wait_idle();
    check("R7 byte step address", 64'(log_addr), 64'h300);

    // R6 request while busy is ignored
    lat = 6;
    ir(4'h1);
    dr({36'h0_0000_0500, 2'd2, 1'b0}, cap);
    t0 = txn;
    dr(39'hABCD, cap);
    dr({36'h0_0000_0600, 2'd2, 1'b1}, cap);
    check("R6 busy reported", 64'(cap[0]), 64'd1);
    wait_idle();
    check("R6 single transfer", 64'(txn - t0), 64'd1);
    check("R6 write address kept", 64'(log_addr), 64'h500);
    dr({36'h0_0000_0600, 2'd2, 1'b1}, cap);
    wait_idle();
    check("R6 repeated address taken", 64'(log_addr), 64'h600);
    lat = 2;

    // R11 instruction change while busy
    dr('0, cap);
    hold = 1'b1;
    dr({36'h0_0000_0700, 2'd2, 1'b1}, cap);
    ir(4'h2);
    check("R11 request kept", 64'(bus_req), 64'd1);
    hold = 1'b0;
    wait_idle();
    check("R11 completed address", 64'(log_addr), 64'h700);
    dr('0, cap);
    check("R11 read data", 64'(cap[32:1]), 64'(mem_val(36'h700)));

    // R10 cancel
    hold = 1'b1;
    t0 = txn;
    dr({36'h0_0000_0800, 2'd2, 1'b1}, cap);
    @(negedge clk);
    instr = 4'h5;
    ir_update = 1'b1;
    #1;
    check("R10 req dropped same cycle", 64'(bus_req), 64'd0);
    @(negedge clk);
    ir_update = 1'b0;
    stray_data = 32'hDEAD_BEEF;
    stray_ack = 1'b1;
    @(negedge clk);
    stray_ack = 1'b0;
    hold = 1'b0;
    dr('0, cap);
    check("R10 busy cleared", 64'(cap[0]), 64'd0);
    check("R10 late ack ignored", 64'(cap[32:1]), 64'(mem_val(36'h700)));
    check("R10 no transfer", 64'(txn - t0), 64'd0);

    // R9 countdown, N = 5
    ir(4'h6);
    dr(39'd5, cap);
    repeat (5) @(negedge clk);
    dr_capture = 1'b1;
    @(negedge clk);
    check("R9 busy at N+1", 64'(scan_out[0]), 64'd1);
    @(negedge clk);
    dr_capture = 1'b0;
    check("R9 clear at N+2", 64'(scan_out[0]), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule